// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This unit compares two IEEE-754 operands and turns the relation between them into a four-bit condition code. The code sets negative, zero, carry and overflow bits in a fixed pattern for each relation: equal, less than, greater than, or unordered. A format input selects single precision, which uses the low 32 bits of each operand bus, or double precision, which uses all 64 bits. A mode input selects a quiet compare or a signalling compare. The two modes differ only in when the invalid-operation flag is raised.

A caller presents both operands, the format and the mode together with a one-cycle strobe. On the next clock edge the unit registers the flags and the invalid indication and raises a done pulse for one cycle. The registered results hold until the next strobe. Subnormal operands are compared exactly, with no flushing. Positive zero and negative zero compare equal.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When the operands are equal, flags = 4'b0110 (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). This includes +0 against -0 in both formats.
- R2: When operand A is less than operand B, flags = 4'b1000.
- R3: When operand A is greater than operand B, flags = 4'b0010.
- R4: When either operand is a NaN (exponent all ones, fraction nonzero), flags = 4'b0011.
- R5: Non-NaN values are ordered by sign first, then by the exponent-and-fraction magnitude. The magnitude order is reversed when both values are negative. Subnormals and infinities are ordered exactly.
- R6: With fmt_dbl = 0, the operands are binary32 values in bits [31:0], and bits [63:32] have no effect. With fmt_dbl = 1, the operands are binary64 values.
- R7: With signal_mode = 0, invalid is 1 only if an operand is a signalling NaN, that is, a NaN whose fraction MSB is 0.
- R8: With signal_mode = 1, invalid is 1 if either operand is any NaN.
- R9: flags and invalid take the result of a strobed input on the clock edge where in_valid is sampled high. done is 1 for exactly the cycle after each strobe.
- R10: Reset clears flags, invalid and done to 0. Without a strobe, flags and invalid keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: operands, format and mode are valid |
| fmt_dbl | input | 1 | 0 = single precision, 1 = double precision |
| signal_mode | input | 1 | 0 = quiet compare, 1 = signalling compare |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| done | output | 1 | One-cycle pulse when the results are updated |
| flags | output | 4 | Condition code {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The unit has a single register stage, so any internal error shows at the ports in the cycle right after the strobe. The bench sweeps every pair from a table of special values in both formats and both modes: signed zeros, the smallest and largest subnormals, the smallest normal, one, two, the largest finite value, infinities, and quiet and signalling NaNs. It derives each expected relation from the value's position in a sorted table. A wrong sign or magnitude decode shows up as a flag code that does not match that position. A wrong NaN decode shows up as an unordered code or an invalid value where none is expected. In single format the upper operand bits are filled with junk, so a format mux that picks the wrong bits is exposed.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int MAG_W     = DP_EXP_W + DP_FRAC_W;
    localparam int FLAG_W    = 4;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             is_zero;
        logic             is_nan;
        logic             is_snan;
    } opnd_t;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_t;

    // Condition code layout: {N, Z, C, V}
    function automatic logic [FLAG_W-1:0] rel_to_flags(rel_t r);
        case (r)
            REL_EQ:  return 4'b0110;
            REL_LT:  return 4'b1000;
            REL_GT:  return 4'b0010;
            default: return 4'b0011;
        endcase
    endfunction
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] bits,
    output opnd_t                 info
);
    logic [EXP_W-1:0]  expf;
    logic [FRAC_W-1:0] frac;

    assign expf = bits[EXP_W+FRAC_W-1:FRAC_W];
    assign frac = bits[FRAC_W-1:0];

    always_comb begin
        info.sign    = bits[EXP_W+FRAC_W];
        info.mag     = MAG_W'({expf, frac});
        info.is_zero = ~|{expf, frac};
        info.is_nan  = (&expf) & (|frac);
        info.is_snan = (&expf) & (|frac) & ~frac[FRAC_W-1];
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    input  logic  signal_mode,
    output rel_t  rel,
    output logic  inv
);
    logic mag_lt, mag_eq;

    assign mag_lt = a.mag < b.mag;
    assign mag_eq = a.mag == b.mag;

    always_comb begin
        if (a.is_nan || b.is_nan)
            rel = REL_UN;
        else if (a.is_zero && b.is_zero)
            rel = REL_EQ;
        else if (a.sign != b.sign)
            rel = a.sign ? REL_LT : REL_GT;
        else if (mag_eq)
            rel = REL_EQ;
        else if (mag_lt ^ a.sign)
            rel = REL_LT;
        else
            rel = REL_GT;
    end

    assign inv = signal_mode ? (a.is_nan | b.is_nan) : (a.is_snan | b.is_snan);
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              fmt_dbl,
    input  logic              signal_mode,
    input  logic [DP_W-1:0]   op_a,
    input  logic [DP_W-1:0]   op_b,
    output logic              done,
    output logic [FLAG_W-1:0] flags,
    output logic              invalid
);
    logic [DP_W-1:0] ops [2];
    opnd_t           sel [2];
    rel_t            rel;
    logic            inv;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        opnd_t sp_info, dp_info;

        fcmp_decode #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
            .bits (ops[g][SP_W-1:0]),
            .info (sp_info)
        );
        fcmp_decode #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
            .bits (ops[g]),
            .info (dp_info)
        );

        assign sel[g] = fmt_dbl ? dp_info : sp_info;
    end

    fcmp_relate u_rel (
        .a           (sel[0]),
        .b           (sel[1]),
        .signal_mode (signal_mode),
        .rel         (rel),
        .inv         (inv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            flags   <= '0;
            invalid <= 1'b0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                flags   <= rel_to_flags(rel);
                invalid <= inv;
            end
        end
    end
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       signal_mode,
    input logic       done,
    input logic [3:0] flags,
    input logic       invalid
);
    // R9
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(flags) && $stable(invalid)));

    // R4
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (flags == 4'b0110 || flags == 4'b1000 ||
                  flags == 4'b0010 || flags == 4'b0011));

    // R7
    invalid_needs_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (done && invalid) |-> (flags == 4'b0011));

    // R8
    signal_any_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && signal_mode) |=> (invalid == (flags == 4'b0011)));
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .signal_mode (signal_mode),
    .done        (done),
    .flags       (flags),
    .invalid     (invalid)
);

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVAL = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic        signal_mode = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        done;
    logic [3:0]  flags;
    logic        invalid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_flag_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
        .signal_mode(signal_mode), .op_a(op_a), .op_b(op_b),
        .done(done), .flags(flags), .invalid(invalid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Value table: idx 0..7 negative, magnitude 7-idx; idx 8..15 positive,
    // magnitude idx-8; 16 +qNaN, 17 -qNaN, 18 +sNaN, 19 -sNaN
    function automatic logic [63:0] mag_of(bit dbl, int m);
        if (dbl) begin
            case (m)
                0: return 64'h0;
                1: return 64'h1;
                2: return 64'h000F_FFFF_FFFF_FFFF;
                3: return 64'h0010_0000_0000_0000;
                4: return 64'h3FF0_0000_0000_0000;
                5: return 64'h4000_0000_0000_0000;
                6: return 64'h7FEF_FFFF_FFFF_FFFF;
                default: return 64'h7FF0_0000_0000_0000;
            endcase
        end else begin
            case (m)
                0: return 64'h0;
                1: return 64'h1;
                2: return 64'h007F_FFFF;
                3: return 64'h0080_0000;
                4: return 64'h3F80_0000;
                5: return 64'h4000_0000;
                6: return 64'h7F7F_FFFF;
                default: return 64'h7F80_0000;
            endcase
        end
    endfunction

    function automatic logic [63:0] enc(bit dbl, int idx);
        logic [63:0] v;
        logic        s;
        if (idx >= 16) begin
            s = (idx % 2) == 1;
            if (idx < 18) v = dbl ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
            else          v = dbl ? 64'h7FF0_0000_0000_0001 : 64'h7F80_0001;
        end else begin
            s = idx < 8;
            v = mag_of(dbl, s ? 7 - idx : idx - 8);
        end
        if (dbl) v[63] = s;
        else     v = {32'hDEAD_BEEF, s, v[30:0]}; // junk upper half, R6
        return v;
    endfunction

    function automatic int rank(int idx);
        return (idx >= 8) ? idx - 1 : idx;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] exp_f;
        logic       exp_i;
        string      tag;
        repeat (3) @(negedge clk);
        chk("R10 reset flags", 64'(flags), 64'h0);
        chk("R10 reset invalid", 64'(invalid), 64'h0);
        chk("R10 reset done", 64'(done), 64'h0);
        rst = 1'b0;
        for (int f = 0; f < 2; f++) begin
            for (int md = 0; md < 2; md++) begin
                for (int i = 0; i < NVAL; i++) begin
                    for (int j = 0; j < NVAL; j++) begin
                        @(negedge clk);
                        fmt_dbl = f[0];
                        signal_mode = md[0];
                        op_a = enc(f[0], i);
                        op_b = enc(f[0], j);
                        in_valid = 1'b1;
                        if (i >= 16 || j >= 16) begin
                            exp_f = 4'b0011; tag = "R4";
                        end else if (rank(i) == rank(j)) begin
                            exp_f = 4'b0110; tag = "R1 R5";
                        end else if (rank(i) < rank(j)) begin
                            exp_f = 4'b1000; tag = "R2 R5";
                        end else begin
                            exp_f = 4'b0010; tag = "R3 R5";
                        end
                        if (md == 1) exp_i = (i >= 16 || j >= 16);
                        else         exp_i = (i >= 18 || j >= 18);
                        @(negedge clk);
                        in_valid = 1'b0;
                        chk("R9 done after strobe", 64'(done), 64'h1);
                        chk({tag, f == 0 ? " R6 single" : " R6 double"}, 64'(flags), 64'(exp_f));
                        chk(md == 1 ? "R8 invalid" : "R7 invalid", 64'(invalid), 64'(exp_i));
                        // Idle cycle with changed inputs: results must hold
                        op_a = enc(f[0], 16);
                        signal_mode = 1'b1;
                        @(negedge clk);
                        chk("R9 done single pulse", 64'(done), 64'h0);
                        chk("R10 flags hold", 64'(flags), 64'(exp_f));
                        chk("R10 invalid hold", 64'(invalid), 64'(exp_i));
                    end
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule